// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block lets a clocked system read and write an external, unclocked static RAM of 65,536 sixteen-bit words. The RAM has one shared bidirectional data bus and two active-low byte-lane enables. Bits 7:0 belong to the low lane and bits 15:8 to the high lane. On the system side, a request carries an address, write data, a two-bit lane mask and a direction flag. The request is taken on a valid/ready handshake. Read results come back on a data port with a one-cycle strobe.

All memory-side strobes are driven from registers. Each access is a fixed sequence of states:

- `ST_IDLE` moves to `ST_WR_SETUP` or `ST_RD_SETUP` on an accepted request.
- A write runs `ST_WR_SETUP` → `ST_WR_PULSE` (held for `WP_CYC` clocks) → `ST_WR_END` → `ST_IDLE`.
- A read runs `ST_RD_SETUP` → `ST_RD_ACCESS` (held for `RD_CYC` clocks) → `ST_RD_TURN` (held for `TURN_CYC` clocks) → `ST_IDLE`.

The nanosecond timing figures of the RAM are parameters. They are turned into clock counts by rounding up against `CLK_PS`, with a minimum of one clock:

- `WP_CYC = ceil(max(T_WP, T_DW)/CLK)`
- `RD_CYC = max(ceil(T_OE/CLK), ceil(T_AA/CLK) - 1)`
- `TURN_CYC = ceil(T_HZ/CLK)`

With the defaults (a 4 ns clock and a 10 ns part) these give 2, 2 and 2.

Top module: `sram_ctrl`

## Requirements
- R1: In and after reset, with no request accepted: `req_ready`=1, `mem_ce_n`=`mem_we_n`=`mem_oe_n`=1, both lane enables are 1, `mem_dq_oe`=0 and `rsp_valid`=0.
- R2: A request is taken only at a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from that edge until the access ends. A request presented while `req_ready` is 0 has no effect on memory contents.
- R3: A write takes one setup clock (select low, write high, data driven), then `WP_CYC` clocks with `mem_we_n` low, then one clock with write high and select and data still held. `req_ready` is therefore low for 2+`WP_CYC` cycles.
- R4: A read takes one setup clock with `mem_oe_n` high, then `RD_CYC` clocks with `mem_oe_n` low. `mem_dq_in` is captured at the last of those clocks. After that come `TURN_CYC` deselected clocks, so `req_ready` is low for 1+`RD_CYC`+`TURN_CYC` cycles. `rsp_valid` is high for exactly one cycle per read, in the cycle after the capture, and reads return in request order.
- R5: Mask bit 0 selects bits 7:0 through `mem_lb_n`, and mask bit 1 selects bits 15:8 through `mem_ub_n`. A lane enable is low only when its mask bit is 1 and only during the access. A write leaves unmasked bytes unchanged, and a read returns 0 in unmasked bytes.
- R6: With mask 00 the full access sequence still runs, but no lane enable goes low. The memory is unchanged, and a read returns 0 with its `rsp_valid` pulse.
- R7: `mem_oe_n` stays high throughout every write, and `mem_we_n` stays high throughout every read.
- R8: `mem_dq_oe` is never 1 while `mem_oe_n` is 0, and it is 0 in the clock before `mem_oe_n` falls. After `mem_oe_n` rises, at least `TURN_CYC` clocks pass before `mem_dq_oe` rises.
- R9: While `mem_we_n` is low, `mem_addr`, `mem_dq_out` and both lane enables do not change.
- R10: The write pulse lasts at least T_WP. At the capture edge, `mem_oe_n` has been low for at least T_OE and the address has been stable for at least T_AA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask, bit 0 = low byte, bit 1 = high byte |
| rsp_valid | output | 1 | One-cycle read-result strobe |
| rsp_rdata | output | 16 | Read result, unmasked bytes zero |
| mem_addr | output | 16 | RAM address |
| mem_ce_n | output | 1 | RAM select, active low |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_lb_n | output | 1 | Low byte lane enable, active low |
| mem_ub_n | output | 1 | High byte lane enable, active low |
| mem_dq_out | output | 16 | Data driven toward the RAM |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_out` |
| mem_dq_in | input | 16 | Data received from the RAM |

## Verification
The bench uses a timed RAM model. The model returns a garbage pattern until both the address and output-enable delays have elapsed, so a read window that is too short returns wrong data instead of passing by luck. Partial-mask writes go over a known word, and unmasked lanes return a fixed non-zero byte. A controller that writes or reports an unselected byte is therefore caught. A read followed at once by a write exercises the turnaround: a design that drops the dead clocks or drives the bus during output enable trips the contention and gap checks. A request held high during a busy read would, in a design that ignores `req_ready`, overwrite a word that is later read back unchanged.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_END,
        ST_RD_SETUP,
        ST_RD_ACCESS,
        ST_RD_TURN
    } sram_state_e;

    // Round a time in picoseconds up to whole clocks, never below one.
    function automatic int cyc_of(input int t_ps, input int clk_ps);
        int c;
        c = (t_ps + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
module sram_ctrl_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/sram_ctrl_rdcap.sv
module sram_ctrl_rdcap #(
    parameter int LANES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               capture,
    input  logic [LANES-1:0]   mask,
    input  logic [LANES*8-1:0] dq_in,
    output logic [LANES*8-1:0] rdata,
    output logic               valid
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rdata[g*8 +: 8] <= '0;
            end else if (capture) begin
                rdata[g*8 +: 8] <= mask[g] ? dq_in[g*8 +: 8] : 8'h00;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) valid <= 1'b0;
        else        valid <= capture;
    end

    // R4
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CLK_PS = 4000,
    parameter int T_AA_PS = 10000,
    parameter int T_OE_PS = 5000,
    parameter int T_WP_PS = 7000,
    parameter int T_DW_PS = 5000,
    parameter int T_HZ_PS = 5000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [15:0]       req_wdata,
    input  logic [1:0]        req_mask,
    output logic              rsp_valid,
    output logic [15:0]       rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic              mem_lb_n,
    output logic              mem_ub_n,
    output logic [15:0]       mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [15:0]       mem_dq_in
);
    localparam int LANES    = 2;
    localparam int WP_CYC   = cyc_of(max2(T_WP_PS, T_DW_PS), CLK_PS);
    localparam int RD_CYC   = max2(cyc_of(T_OE_PS, CLK_PS), cyc_of(T_AA_PS, CLK_PS) - 1);
    localparam int TURN_CYC = cyc_of(T_HZ_PS, CLK_PS);
    localparam int MAX_CYC  = max2(WP_CYC, max2(RD_CYC, TURN_CYC));
    localparam int CNT_W    = $clog2(MAX_CYC + 1);

    sram_state_e        state_q, state_nx;
    logic [ADDR_W-1:0]  addr_q;
    logic [15:0]        wdata_q;
    logic [LANES-1:0]   mask_q, mask_nx;
    logic               accept, active_nx, capture;
    logic               tmr_load, tmr_done;
    logic [CNT_W-1:0]   tmr_val;
    logic               ce_n_q, we_n_q, oe_n_q, dq_oe_q;
    logic [LANES-1:0]   lane_n_q;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign capture   = (state_q == ST_RD_ACCESS) && tmr_done;
    assign mask_nx   = accept ? req_mask : mask_q;

    sram_ctrl_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    // Next-state decision
    always_comb begin
        state_nx = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) state_nx = req_write ? ST_WR_SETUP : ST_RD_SETUP;
            end
            ST_WR_SETUP: begin
                state_nx = ST_WR_PULSE;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(WP_CYC - 1);
            end
            ST_WR_PULSE: begin
                if (tmr_done) state_nx = ST_WR_END;
            end
            ST_WR_END: begin
                state_nx = ST_IDLE;
            end
            ST_RD_SETUP: begin
                state_nx = ST_RD_ACCESS;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(RD_CYC - 1);
            end
            ST_RD_ACCESS: begin
                if (tmr_done) begin
                    state_nx = ST_RD_TURN;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(TURN_CYC - 1);
                end
            end
            ST_RD_TURN: begin
                if (tmr_done) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // Request fields held for the whole access
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            mask_q  <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            mask_q  <= req_mask;
        end
    end

    // Memory strobes, registered from the next state so no decode glitches reach the pins
    assign active_nx = state_nx inside {ST_WR_SETUP, ST_WR_PULSE, ST_WR_END,
                                        ST_RD_SETUP, ST_RD_ACCESS};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ce_n_q   <= 1'b1;
            we_n_q   <= 1'b1;
            oe_n_q   <= 1'b1;
            dq_oe_q  <= 1'b0;
            lane_n_q <= '1;
        end else begin
            ce_n_q   <= !active_nx;
            we_n_q   <= (state_nx != ST_WR_PULSE);
            oe_n_q   <= (state_nx != ST_RD_ACCESS);
            dq_oe_q  <= state_nx inside {ST_WR_SETUP, ST_WR_PULSE, ST_WR_END};
            lane_n_q <= active_nx ? ~mask_nx : '1;
        end
    end

    assign mem_addr   = addr_q;
    assign mem_dq_out = wdata_q;
    assign mem_ce_n   = ce_n_q;
    assign mem_we_n   = we_n_q;
    assign mem_oe_n   = oe_n_q;
    assign mem_dq_oe  = dq_oe_q;
    assign mem_lb_n   = lane_n_q[0];
    assign mem_ub_n   = lane_n_q[1];

    sram_ctrl_rdcap #(.LANES(LANES)) u_rdcap (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .mask    (mask_q),
        .dq_in   (mem_dq_in),
        .rdata   (rsp_rdata),
        .valid   (rsp_valid)
    );

    // R2
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R7
    oe_idle_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);

    // R8
    bus_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_dq_oe && !mem_oe_n));

    // R8
    release_before_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n) |-> !$past(mem_dq_oe));

    // R8
    turn_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n) |=> !mem_dq_oe);

    // R9
    pulse_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && !$past(mem_we_n)) |->
            ($stable(mem_addr) && $stable(mem_dq_out) && $stable({mem_lb_n, mem_ub_n})));
endmodule

// File: tb/sram_ctrl_tb.sv
`timescale 1ns/1ps
module sram_ctrl_tb;
    localparam real CLK_NS = 4.0;
    localparam real T_AA = 10.0, T_OE = 5.0, T_WP = 7.0, T_DW = 5.0, T_HZ = 5.0;
    localparam int  WP   = $rtoi($ceil(((T_WP > T_DW) ? T_WP : T_DW) / CLK_NS));
    localparam int  RDA  = $rtoi($ceil(T_OE / CLK_NS));
    localparam int  RDB  = $rtoi($ceil(T_AA / CLK_NS)) - 1;
    localparam int  RD   = (RDA > RDB) ? RDA : RDB;
    localparam int  TURN = $rtoi($ceil(T_HZ / CLK_NS));

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [15:0] req_addr = '0, req_wdata = '0;
    logic [1:0] req_mask = '0;
    logic req_ready, rsp_valid, mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe;
    logic [15:0] rsp_rdata, mem_addr, mem_dq_out;
    logic [15:0] mem_dq_in = 16'h0F0F;

    int n_chk = 0, n_fail = 0;
    logic [15:0] ref_mem [int];
    logic [15:0] ram [int];
    logic [15:0] exp_q [$];

    always #2 clk = ~clk;

    sram_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
        .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", rq, act, exp);
        end
    endtask

    function automatic logic [15:0] rd_of(input logic [15:0] w, input logic [1:0] m);
        return {m[1] ? w[15:8] : 8'h00, m[0] ? w[7:0] : 8'h00};
    endfunction

    function automatic logic [15:0] ref_word(input logic [15:0] a);
        return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 16'h0000;
    endfunction

    // ---------------- timed RAM model ----------------
    realtime t_addr = 0, t_oe = 0, t_we = 0;
    logic [15:0] we_addr, we_data;
    logic [1:0]  we_lanes;
    bit prev_dq_oe = 0, prev_we_n = 1, prev_v = 0;
    int cyc = 0, last_oe_low = -100;

    always @(mem_addr or mem_ce_n) t_addr = $realtime;
    always @(negedge mem_oe_n) t_oe = $realtime;
    always @(negedge mem_we_n) t_we = $realtime;

    always @(posedge mem_we_n) begin
        if (rst_n) begin
            // R10 write pulse width (in ps)
            chk(($realtime - t_we) >= T_WP, "R10 write pulse width", int'(($realtime - t_we) * 1000), int'(T_WP * 1000));
            if (!mem_ce_n) begin
                logic [15:0] w;
                w = ram.exists(int'(mem_addr)) ? ram[int'(mem_addr)] : 16'h0000;
                if (!mem_lb_n) w[7:0]  = mem_dq_out[7:0];
                if (!mem_ub_n) w[15:8] = mem_dq_out[15:8];
                ram[int'(mem_addr)] = w;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (!mem_ce_n && mem_we_n && !mem_oe_n) begin
                logic [15:0] w;
                bit ok;
                w  = ram.exists(int'(mem_addr)) ? ram[int'(mem_addr)] : 16'h0000;
                ok = (($realtime - t_oe) >= T_OE) && (($realtime - t_addr) >= T_AA);
                mem_dq_in = ok ? {mem_ub_n ? 8'hA5 : w[15:8], mem_lb_n ? 8'hA5 : w[7:0]} : 16'h5A5A;
            end else begin
                mem_dq_in = 16'h0F0F;
            end
            if (!mem_oe_n) begin
                chk(!mem_dq_oe, "R8 drive during output enable", mem_dq_oe, 0);
                chk(!prev_dq_oe, "R8 drive in clock before output enable", prev_dq_oe, 0);
                chk(mem_we_n, "R7 write strobe during read", mem_we_n, 1);
                last_oe_low = cyc;
            end
            if (mem_dq_oe && !prev_dq_oe)
                chk((cyc - last_oe_low) > TURN, "R8 turnaround gap", cyc - last_oe_low, TURN + 1);
            if (!mem_we_n) begin
                chk(mem_oe_n, "R7 output enable during write", mem_oe_n, 1);
                if (prev_we_n) begin
                    we_addr = mem_addr; we_data = mem_dq_out; we_lanes = {mem_ub_n, mem_lb_n};
                end else begin
                    chk(mem_addr == we_addr, "R9 address during pulse", mem_addr, we_addr);
                    chk(mem_dq_out == we_data, "R9 data during pulse", mem_dq_out, we_data);
                    chk({mem_ub_n, mem_lb_n} == we_lanes, "R9 lanes during pulse", {mem_ub_n, mem_lb_n}, we_lanes);
                end
            end
            prev_dq_oe = mem_dq_oe;
            prev_we_n  = mem_we_n;
        end
    end

    // ---------------- scoreboard monitor ----------------
    always @(negedge clk) begin
        if (rst_n) begin
            if (rsp_valid) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R4 response with no read outstanding", rsp_rdata, 0);
                end else begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    chk(rsp_rdata == e, "R4/R5 read data", rsp_rdata, e);
                end
                chk(!prev_v, "R4 strobe longer than one cycle", prev_v, 0);
            end
            prev_v = rsp_valid;
        end
    end

    // ---------------- driver ----------------
    task automatic issue(input bit wr, input logic [15:0] a, input logic [15:0] d, input logic [1:0] m);
        int busy;
        while (!req_ready) @(negedge clk);
        req_write = wr; req_addr = a; req_wdata = d; req_mask = m; req_valid = 1'b1;
        if (!wr) exp_q.push_back(rd_of(ref_word(a), m));
        @(negedge clk);
        req_valid = 1'b0;
        busy = 0;
        while (!req_ready) begin busy++; @(negedge clk); end
        if (wr) begin
            logic [15:0] w;
            w = ref_word(a);
            if (m[0]) w[7:0]  = d[7:0];
            if (m[1]) w[15:8] = d[15:8];
            ref_mem[int'(a)] = w;
            chk(busy == 2 + WP, "R3 write busy cycles", busy, 2 + WP);
        end else begin
            chk(busy == 1 + RD + TURN, "R4 read busy cycles", busy, 1 + RD + TURN);
        end
    endtask

    initial begin
        #(200000 * 4);
        chk(0, "watchdog expired", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 during reset
        chk(req_ready && mem_ce_n && mem_we_n && mem_oe_n && mem_lb_n && mem_ub_n && !mem_dq_oe && !rsp_valid,
            "R1 reset outputs", {req_ready, mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe, rsp_valid}, 8'hFC);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1 idle after reset
        chk(req_ready && mem_ce_n && !mem_dq_oe && !rsp_valid, "R1 idle outputs",
            {req_ready, mem_ce_n, mem_dq_oe, rsp_valid}, 4'hC);

        // R3 R4 full-word traffic, including the top address
        issue(1, 16'h0000, 16'h1234, 2'b11);
        issue(0, 16'h0000, 16'h0000, 2'b11);
        issue(1, 16'hFFFF, 16'hBEEF, 2'b11);
        issue(0, 16'hFFFF, 16'h0000, 2'b11);

        // R5 lane masks over a known word
        issue(1, 16'h0042, 16'hA0B1, 2'b11);
        issue(1, 16'h0042, 16'h55CC, 2'b01);
        issue(0, 16'h0042, 16'h0000, 2'b11);
        issue(1, 16'h0042, 16'h77EE, 2'b10);
        issue(0, 16'h0042, 16'h0000, 2'b11);
        issue(0, 16'h0042, 16'h0000, 2'b01);
        issue(0, 16'h0042, 16'h0000, 2'b10);

        // R6 empty mask: nothing written, read returns zero
        issue(1, 16'h0042, 16'h0000, 2'b00);
        issue(0, 16'h0042, 16'h0000, 2'b00);
        issue(0, 16'h0042, 16'h0000, 2'b11);

        // R2 request held during a busy read is ignored
        while (!req_ready) @(negedge clk);
        req_write = 0; req_addr = 16'h0042; req_mask = 2'b11; req_valid = 1'b1;
        exp_q.push_back(rd_of(ref_word(16'h0042), 2'b11));
        @(negedge clk);
        req_write = 1; req_wdata = 16'hDEAD;
        for (int i = 0; i < 2; i++) begin
            chk(!req_ready, "R2 ready low while busy", req_ready, 0);
            @(negedge clk);
        end
        req_valid = 1'b0;
        issue(0, 16'h0042, 16'h0000, 2'b11);

        // R8 read followed at once by write, then several patterns
        for (int i = 0; i < 8; i++) begin
            logic [15:0] a, d;
            a = 16'(i * 16'h1111 + 3);
            d = 16'(16'hC3A5 ^ (i * 16'h0F1E));
            issue(1, a, d, 2'b11);
            issue(0, a, 16'h0000, 2'b11);
            issue(1, a, ~d, 2'(i % 4));
            issue(0, a, 16'h0000, 2'b11);
        end

        repeat (10) @(negedge clk);
        chk(exp_q.size() == 0, "R4 reads left without response", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule